// File: doc/BRIEF.md
# ADC Channel Conversion Sequencer and Accumulator

This block is the digital controller for one channel of a successive-approximation converter. It watches two trigger lines: a start trigger with selectable polarity and a rising-edge re-trigger. It runs a sampling phase timed in half-TAD steps and then sends a one-cycle conversion request to the analog core. It collects each 12-bit result, which arrives with a done strobe. The result is delivered in one of four ways, chosen by a 2-bit mode field:
- a single sample;
- a window-gated accumulation;
- a counted integration;
- an oversampled sum that is decimated by a fixed right shift.

The final word can be unsigned or two's complement. It can be right aligned or placed at the top of a 32-bit output word. Interrupt pulses can mark every conversion or only the final word. In single-sample mode the interrupt can instead be moved to the start of sampling. All configuration arrives on static input ports. These ports must be held steady while a sequence is running.

Top module: `adcChanSeq`

## Requirements
- R1: Mode 0 (single): an active edge on the start trigger makes one conversion. The sample is delivered on `dataOut` with a one-cycle `dataValid` in the cycle after `convDone`, and `dataOut` holds its value at all other times.
- R2: With `cfgTrg1Pol`=0 a rising edge of `trg1` starts a sequence and high is its active level. With `cfgTrg1Pol`=1 a falling edge starts it and low is its active level. An edge of the opposite direction starts nothing.
- R3: After a start or re-trigger, `convReq` rises once 2·`cfgSamc`+1 cycles with `halfTadTick` high have elapsed. While `halfTadTick` is low the sampling phase does not advance.
- R4: Mode 1 (window): every conversion, including the first, is started by a rising edge of `trg2`. A result is added only if `trg1` is at its active level when `convDone` arrives. The sequence ends after `cfgCount` conversions, with a result width of 28 bits.
- R5: Mode 2 (integration): `trg1` starts the first conversion and `trg2` starts each later one. The sum of `cfgCount` samples is delivered, with a result width of 28 bits.
- R6: Mode 3 (oversampling): `cfgAccNum` values 0, 1, 2 and 3 select 4, 16, 64 and 256 samples. The sum is shifted right by 1, 2, 3 or 4 bits, giving results of 13 to 16 bits. `cfgAccNum` has no effect in the other modes.
- R7: With `cfgIrqSel`=0, `irq` pulses for one cycle after every conversion. With `cfgIrqSel`=1 it pulses only together with `dataValid`.
- R8: With `cfgEarlyEn`=1 in mode 0, `irq` pulses in the first cycle of sampling and not at the result. In the other modes `cfgEarlyEn` is ignored.
- R9: With `cfgDiff`=1, samples are two's complement, the sum and the decimating shift are signed, and the output is sign extended. With `cfgFrac`=1, the result's low W bits are placed at the top of the 32-bit word, where W is 12 in mode 0, 13 to 16 in mode 3, and 28 in modes 1 and 2.
- R10: Trigger edges that arrive while `busy` is high are ignored. `done` sets when the final word is delivered and clears when the next sequence starts.
- R11: After reset, `busy`, `done`, `convReq`, `dataValid`, `irq` and `dataOut` are zero. `convReq` is a single-cycle pulse and is raised only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfTadTick | input | 1 | Clock enable, one pulse per half TAD |
| trg1 | input | 1 | Start trigger / window gate |
| trg2 | input | 1 | Re-trigger, rising edge active |
| cfgMode | input | 2 | 0 single, 1 window, 2 integration, 3 oversampling |
| cfgAccNum | input | 2 | Oversampling ratio select |
| cfgTrg1Pol | input | 1 | Start trigger polarity, 1 = active low |
| cfgSamc | input | 5 | Sampling time code |
| cfgIrqSel | input | 1 | 1 = interrupt on final data only |
| cfgEarlyEn | input | 1 | Early interrupt enable, used in mode 0 only |
| cfgDiff | input | 1 | Signed two's complement samples and output |
| cfgFrac | input | 1 | Left-aligned output |
| cfgCount | input | 16 | Conversion count for modes 1 and 2 |
| convDone | input | 1 | Converter result strobe |
| convData | input | 12 | Converter result |
| convReq | output | 1 | Conversion request pulse |
| dataOut | output | 32 | Formatted final result |
| dataValid | output | 1 | One-cycle pulse when `dataOut` updates |
| irq | output | 1 | Channel interrupt pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final word delivered, sticky until the next start |

## Verification
The checks are timed against the trigger and the converter strobes.
- A trigger driven just after one edge is seen at the following edge. With the half-TAD tick held high, `convReq` then becomes visible exactly 2·`cfgSamc`+2 sampling points later; with the tick released late, it appears after 2·`cfgSamc`+1 more ticked cycles.
- `dataValid`, `irq` and the new `dataOut` are due at the first sampling point after the `convDone` cycle.
- An early interrupt is due at the first sampling point after the start trigger.

The bench counts falling edges from each stimulus and compares each signal at exactly that count. Expected results come from a behavioural sum over the sample queue in the bench.

// File: rtl/adcSeqPkg.sv
`timescale 1ns/1ps
package adcSeqPkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_WINDOW = 2'd1,
    MODE_INTEG  = 2'd2,
    MODE_OVER   = 2'd3
  } smpMode_e;

  // Strobes from the sequencer into the accumulator datapath.
  typedef struct packed {
    logic clrAcc;
    logic addSample;
    logic latchOut;
  } seqStrobe_t;
endpackage

// File: rtl/adcSeqCtrl.sv
`timescale 1ns/1ps
module adcSeqCtrl import adcSeqPkg::*; #(
  parameter int CNT_W  = 16,
  parameter int SAMC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTadTick,
  input  logic              trg1,
  input  logic              trg2,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgAccNum,
  input  logic              cfgTrg1Pol,
  input  logic [SAMC_W-1:0] cfgSamc,
  input  logic              cfgIrqSel,
  input  logic              cfgEarlyEn,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              convDone,
  output seqStrobe_t        strb,
  output logic              convReq,
  output logic              irq,
  output logic              dataValid,
  output logic              busy,
  output logic              done
);
  localparam int TICK_W = SAMC_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SAMPLE, S_CONV, S_WAIT} seqState_e;

  seqState_e         state;
  logic              trg1Q, trg2Q;
  logic [TICK_W-1:0] tickCnt;
  logic [CNT_W-1:0]  convCnt;
  logic [CNT_W-1:0]  target;
  logic              trg1Act, trg1Edge, trg2Edge, startEv, lastConv, earlyUsed;
  smpMode_e          mode;

  assign mode      = smpMode_e'(cfgMode);
  assign trg1Act   = trg1 ^ cfgTrg1Pol;
  assign trg1Edge  = trg1Act & ~(trg1Q ^ cfgTrg1Pol);
  assign trg2Edge  = trg2 & ~trg2Q;
  assign startEv   = (state == S_IDLE) & ((mode == MODE_WINDOW) ? trg2Edge : trg1Edge);
  assign earlyUsed = (mode == MODE_SINGLE) & cfgEarlyEn;
  assign busy      = (state != S_IDLE);

  always_comb begin
    case (mode)
      MODE_SINGLE: target = CNT_W'(1);
      MODE_OVER:   target = CNT_W'(1) << (4'd2 + {1'b0, cfgAccNum, 1'b0});
      default:     target = cfgCount;
    endcase
  end

  assign lastConv = (({1'b0, convCnt} + (CNT_W+1)'(1)) >= {1'b0, target});

  assign strb.clrAcc    = startEv;
  assign strb.addSample = (state == S_CONV) & convDone & ((mode != MODE_WINDOW) | trg1Act);
  assign strb.latchOut  = (state == S_CONV) & convDone & lastConv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      trg1Q     <= 1'b0;
      trg2Q     <= 1'b0;
      tickCnt   <= '0;
      convCnt   <= '0;
      convReq   <= 1'b0;
      irq       <= 1'b0;
      dataValid <= 1'b0;
      done      <= 1'b0;
    end else begin
      trg1Q     <= trg1;
      trg2Q     <= trg2;
      convReq   <= 1'b0;
      irq       <= 1'b0;
      dataValid <= 1'b0;
      case (state)
        S_IDLE: if (startEv) begin
          state   <= S_SAMPLE;
          tickCnt <= '0;
          convCnt <= '0;
          done    <= 1'b0;
          irq     <= earlyUsed;
        end
        S_SAMPLE: if (halfTadTick) begin
          if (tickCnt == {cfgSamc, 1'b0}) begin
            state   <= S_CONV;
            convReq <= 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_CONV: if (convDone) begin
          convCnt <= convCnt + 1'b1;
          irq     <= ~earlyUsed & (lastConv | ~cfgIrqSel);
          if (lastConv) begin
            state     <= S_IDLE;
            dataValid <= 1'b1;
            done      <= 1'b1;
          end else begin
            state <= S_WAIT;
          end
        end
        default: if (trg2Edge) begin
          state   <= S_SAMPLE;
          tickCnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/adcSeqData.sv
`timescale 1ns/1ps
module adcSeqData import adcSeqPkg::*; #(
  parameter int RES_W = 12,
  parameter int ACC_W = 28,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [RES_W-1:0] convData,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgAccNum,
  input  logic             cfgDiff,
  input  logic             cfgFrac,
  output logic [OUT_W-1:0] dataOut
);
  localparam int SH_W  = $clog2(OUT_W + 1);
  localparam int EXT_W = OUT_W - ACC_W;

  logic [ACC_W-1:0] acc, sampleExt, sumNow, shifted;
  logic [OUT_W-1:0] widened, formatted;
  logic [SH_W-1:0]  natW, leftSh;
  logic [2:0]       decShift;
  smpMode_e         mode;

  assign mode      = smpMode_e'(cfgMode);
  assign sampleExt = cfgDiff ? {{(ACC_W-RES_W){convData[RES_W-1]}}, convData}
                             : {{(ACC_W-RES_W){1'b0}}, convData};
  assign sumNow    = strb.addSample ? acc + sampleExt : acc;
  assign decShift  = (mode == MODE_OVER) ? ({1'b0, cfgAccNum} + 3'd1) : 3'd0;

  always_comb begin
    if (cfgDiff) shifted = ACC_W'($signed(sumNow) >>> decShift);
    else         shifted = sumNow >> decShift;
  end

  always_comb begin
    case (mode)
      MODE_SINGLE: natW = SH_W'(RES_W);
      MODE_OVER:   natW = SH_W'(RES_W + 1) + SH_W'(cfgAccNum);
      default:     natW = SH_W'(ACC_W);
    endcase
  end

  assign leftSh    = SH_W'(OUT_W) - natW;
  assign widened   = {{EXT_W{cfgDiff & shifted[ACC_W-1]}}, shifted};
  assign formatted = cfgFrac ? (widened << leftSh) : widened;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      dataOut <= '0;
    end else begin
      if (strb.clrAcc)         acc <= '0;
      else if (strb.addSample) acc <= sumNow;
      if (strb.latchOut)       dataOut <= formatted;
    end
  end
endmodule

// File: rtl/adcChanSeq.sv
`timescale 1ns/1ps
module adcChanSeq import adcSeqPkg::*; #(
  parameter int RES_W  = 12,
  parameter int CNT_W  = 16,
  parameter int SAMC_W = 5,
  parameter int OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTadTick,
  input  logic              trg1,
  input  logic              trg2,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgAccNum,
  input  logic              cfgTrg1Pol,
  input  logic [SAMC_W-1:0] cfgSamc,
  input  logic              cfgIrqSel,
  input  logic              cfgEarlyEn,
  input  logic              cfgDiff,
  input  logic              cfgFrac,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  output logic              convReq,
  output logic [OUT_W-1:0]  dataOut,
  output logic              dataValid,
  output logic              irq,
  output logic              busy,
  output logic              done
);
  localparam int ACC_W = RES_W + CNT_W;

  seqStrobe_t strb;

  adcSeqCtrl #(.CNT_W(CNT_W), .SAMC_W(SAMC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .halfTadTick(halfTadTick), .trg1(trg1), .trg2(trg2),
    .cfgMode(cfgMode), .cfgAccNum(cfgAccNum), .cfgTrg1Pol(cfgTrg1Pol), .cfgSamc(cfgSamc),
    .cfgIrqSel(cfgIrqSel), .cfgEarlyEn(cfgEarlyEn), .cfgCount(cfgCount), .convDone(convDone),
    .strb(strb), .convReq(convReq), .irq(irq), .dataValid(dataValid), .busy(busy), .done(done)
  );

  adcSeqData #(.RES_W(RES_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .convData(convData), .cfgMode(cfgMode),
    .cfgAccNum(cfgAccNum), .cfgDiff(cfgDiff), .cfgFrac(cfgFrac), .dataOut(dataOut)
  );
endmodule

// File: rtl/adcChanSeqChk.sv
`timescale 1ns/1ps
module adcChanSeqChk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       cfgMode,
  input logic             convReq,
  input logic             dataValid,
  input logic             irq,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] dataOut
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq); // R11
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> busy); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10
  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> done); // R10
  AST_NO_EARLY_MULTI: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && cfgMode != 2'b00) |-> !irq); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable(dataOut)); // R1
endmodule

bind adcChanSeq adcChanSeqChk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .convReq(convReq), .dataValid(dataValid),
  .irq(irq), .busy(busy), .done(done), .dataOut(dataOut)
);

// File: tb/sim_adcChanSeq.sv
`timescale 1ns/1ps
module sim_adcChanSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        halfTadTick = 1'b1;
  logic        trg1 = 1'b0, trg2 = 1'b0;
  logic [1:0]  cfgMode = 2'd0, cfgAccNum = 2'd0;
  logic        cfgTrg1Pol = 1'b0, cfgIrqSel = 1'b0, cfgEarlyEn = 1'b0;
  logic        cfgDiff = 1'b0, cfgFrac = 1'b0;
  logic [4:0]  cfgSamc = 5'd3;
  logic [15:0] cfgCount = 16'd1;
  logic        convDone = 1'b0;
  logic [11:0] convData = 12'd0;
  logic        convReq, dataValid, irq, busy, done;
  logic [31:0] dataOut;

  int checks = 0, fails = 0, cycles = 0;
  logic [11:0] smpQ[$];
  bit          gateQ[$];

  always #2.5 clk = ~clk;

  adcChanSeq u0 (
    .clk(clk), .rstN(rstN), .halfTadTick(halfTadTick), .trg1(trg1), .trg2(trg2),
    .cfgMode(cfgMode), .cfgAccNum(cfgAccNum), .cfgTrg1Pol(cfgTrg1Pol), .cfgSamc(cfgSamc),
    .cfgIrqSel(cfgIrqSel), .cfgEarlyEn(cfgEarlyEn), .cfgDiff(cfgDiff), .cfgFrac(cfgFrac),
    .cfgCount(cfgCount), .convDone(convDone), .convData(convData), .convReq(convReq),
    .dataOut(dataOut), .dataValid(dataValid), .irq(irq), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refResult();
    longint sum = 0;
    int     w;
    logic [31:0] r;
    foreach (smpQ[i]) begin
      if (cfgMode != 2'd1 || gateQ[i])
        sum += cfgDiff ? longint'($signed(smpQ[i])) : longint'(smpQ[i]);
    end
    if (cfgMode == 2'd3) sum = sum >>> (cfgAccNum + 1);
    w = (cfgMode == 2'd0) ? 12 : (cfgMode == 2'd3) ? 13 + int'(cfgAccNum) : 28;
    r = sum[31:0];
    if (cfgFrac) r = r << (32 - w);
    return r;
  endfunction

  // Runs one full sequence over smpQ; start by trg2 when useTrg2 is set.
  task automatic runSeq(input bit useTrg2, input bit pokeBusy, input string req);
    int n = smpQ.size();
    int s = int'(cfgSamc);
    bit act = !cfgTrg1Pol;
    bit win = (cfgMode == 2'd1);
    bit early = (cfgMode == 2'd0) && cfgEarlyEn;
    logic [31:0] exp = refResult();
    trg1 = win ? (gateQ[0] ? act : !act) : !act;
    repeat (2) @(negedge clk);
    if (useTrg2) trg2 = 1'b1; else trg1 = act;
    for (int i = 0; i < n; i++) begin
      int cnt = 0;
      bit last = (i == n - 1);
      while (1) begin
        @(negedge clk);
        cnt++;
        if (cnt == 1) begin
          trg2 = 1'b0;
          if (!win) trg1 = !act;
          if (i == 0) begin
            chk(irq == early, "R8", "irq at sampling start", irq, early);
            chk(busy && !done, "R10", "busy/done after start", {busy, done}, 2'b10);
          end
        end
        if (pokeBusy && cnt == 2) begin trg1 = act; trg2 = 1'b1; end
        if (pokeBusy && cnt == 3) begin trg1 = !act; trg2 = 1'b0; end
        if (convReq || cnt > 400) break;
      end
      chk(cnt == 2*s + 2, pokeBusy ? "R10" : "R3", "cycles to convReq", cnt, 2*s + 2);
      convData = smpQ[i];
      convDone = 1'b1;
      @(negedge clk);
      convDone = 1'b0;
      chk(irq == (!early && (last || !cfgIrqSel)), "R7", "irq after conversion",
          irq, (!early && (last || !cfgIrqSel)));
      chk(dataValid == last, req, "dataValid", dataValid, last);
      if (last) begin
        chk(dataOut == exp, req, "dataOut", dataOut, exp);
        chk(done && !busy, "R10", "done after final", {busy, done}, 2'b01);
      end else begin
        if (win) trg1 = gateQ[i+1] ? act : !act;
        trg2 = 1'b1;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "WD", "watchdog expired", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !convReq && !dataValid && !irq && dataOut == 0, "R11",
        "reset state", {busy, done, convReq, dataValid, irq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: single sample, rising edge, unsigned right aligned
    smpQ = '{12'hABC}; gateQ = '{1};
    runSeq(0, 0, "R1");

    // R2: active-low start, a rising edge must not start anything
    cfgTrg1Pol = 1'b1; cfgSamc = 5'd0; cfgDiff = 1'b1; cfgEarlyEn = 1'b1;
    trg1 = 1'b0; repeat (3) @(negedge clk);
    trg1 = 1'b1; repeat (3) @(negedge clk);
    chk(!busy, "R2", "rising edge with active-low polarity", busy, 0);
    smpQ = '{12'h800};
    runSeq(0, 0, "R9");
    chk(dataOut == 32'hFFFFF800, "R2", "signed single sample", dataOut, 32'hFFFFF800);

    // R9: left aligned unsigned single sample; R10 retrigger during sampling ignored
    cfgTrg1Pol = 1'b0; cfgSamc = 5'd3; cfgDiff = 1'b0; cfgEarlyEn = 1'b0; cfgFrac = 1'b1;
    trg1 = 1'b0;
    smpQ = '{12'h123};
    runSeq(0, 1, "R9");
    chk(dataOut == 32'h12300000, "R9", "fractional single", dataOut, 32'h12300000);

    // R6: 4x oversampling, interrupt on data only, early enable ignored
    cfgMode = 2'd3; cfgAccNum = 2'd0; cfgFrac = 1'b0; cfgIrqSel = 1'b1; cfgEarlyEn = 1'b1;
    cfgSamc = 5'd1;
    smpQ = '{12'h100, 12'h101, 12'h102, 12'h103}; gateQ = '{1, 1, 1, 1};
    runSeq(0, 0, "R6");
    chk(dataOut == 32'h203, "R6", "4 sample decimation", dataOut, 32'h203);

    // R6/R9: 16x of full scale, left aligned 14-bit
    cfgAccNum = 2'd1; cfgFrac = 1'b1; cfgSamc = 5'd0;
    smpQ.delete();
    for (int i = 0; i < 16; i++) smpQ.push_back(12'hFFF);
    runSeq(0, 0, "R6");
    chk(dataOut == 32'hFFF00000, "R6", "16 sample left aligned", dataOut, 32'hFFF00000);

    // R6/R9: 256x of -2 signed
    cfgAccNum = 2'd3; cfgFrac = 1'b0; cfgDiff = 1'b1;
    smpQ.delete();
    for (int i = 0; i < 256; i++) smpQ.push_back(12'hFFE);
    runSeq(0, 0, "R6");
    chk(dataOut == 32'hFFFFFFE0, "R6", "256 sample signed", dataOut, 32'hFFFFFFE0);

    // R5: integration of 5 samples, accnum set but ignored, per-conversion irq
    cfgMode = 2'd2; cfgDiff = 1'b0; cfgIrqSel = 1'b0; cfgCount = 16'd5; cfgSamc = 5'd2;
    smpQ = '{12'd1, 12'd2, 12'd3, 12'd4, 12'd5};
    runSeq(0, 0, "R5");
    chk(dataOut == 32'd15, "R6", "accnum ignored outside oversampling", dataOut, 15);

    // R4: window gated, trg2 start, gate pattern 1,0,1,1, left aligned 28-bit
    cfgMode = 2'd1; cfgCount = 16'd4; cfgFrac = 1'b1; cfgIrqSel = 1'b1;
    smpQ = '{12'd10, 12'd20, 12'd30, 12'd40}; gateQ = '{1, 0, 1, 1};
    runSeq(1, 0, "R4");
    chk(dataOut == 32'h500, "R4", "window sum", dataOut, 32'h500);

    // R3: sampling stalls without half-TAD ticks
    cfgMode = 2'd0; cfgFrac = 1'b0; cfgSamc = 5'd1; cfgEarlyEn = 1'b0; trg1 = 1'b0;
    halfTadTick = 1'b0;
    @(negedge clk); trg1 = 1'b1;
    @(negedge clk); trg1 = 1'b0;
    begin
      bit sawReq = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (convReq) sawReq = 1;
      end
      chk(!sawReq && busy, "R3", "no progress without tick", sawReq, 0);
    end
    halfTadTick = 1'b1;
    begin
      int cnt = 0;
      while (1) begin
        @(negedge clk); cnt++;
        if (convReq || cnt > 100) break;
      end
      chk(cnt == 3, "R3", "ticks to convReq after release", cnt, 3);
    end
    convData = 12'h055; convDone = 1'b1;
    @(negedge clk); convDone = 1'b0;
    chk(dataValid && dataOut == 32'h55, "R1", "result after stalled sampling", dataOut, 32'h55);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule